// File: doc/BRIEF.md
# Clock-Enable Driven Up-Sampler

The block raises the sample rate of a signed data stream by an integer factor inside a design where every part runs on one system clock. Rates are carried by single-cycle enable strobes. A slow source strobe qualifies the input word. A fast destination strobe marks each output slot. In normal use the source strobe fires once for every `FACTOR` destination strobes, and always in the same cycle as one of them. That coinciding slot is the first fast slot of the new input sample.

A parameter picks one of two fill behaviours for the remaining `FACTOR-1` slots of each input period:

- **Hold mode** keeps the last loaded word, so each input word appears `FACTOR` times at the output. It needs no logic beyond the output register.
- **Zero-fill mode** places a two-way selector in front of the output register. The selector emits the input word in the first slot and the constant zero in every other slot.

The output is registered and moves only on destination-strobe cycles. The reset is asynchronous and active low, and its release is synchronised inside the block by a two-stage synchroniser.

Top module: `ce_upsampler`

## Requirements
- R1: While `rst_n` is low, `dout` is zero; asserting `rst_n` clears `dout` without waiting for a clock edge.
- R2: On a clock edge where `dst_en` is 0, `dout` keeps its value; a `src_en` pulse without `dst_en` changes nothing.
- R3: On an edge where `src_en` and `dst_en` are both 1, `dout` takes the value of `din` in both modes.
- R4: In hold mode (`MODE` = 0), an edge with `dst_en` = 1 and `src_en` = 0 leaves `dout` unchanged.
- R5: In zero-fill mode (`MODE` = 1), an edge with `dst_en` = 1 and `src_en` = 0 sets `dout` to zero.
- R6: In zero-fill mode, with one source strobe per `FACTOR` destination strobes, each input period shows the input word in its first destination slot and zero in the other `FACTOR-1` slots.
- R7: In hold mode, under the same strobe pattern, each input word appears in all `FACTOR` destination slots of its period.
- R8: `din` is two's complement; negative words, the most negative word and zero pass through unaltered.
- R9: After `rst_n` rises, the first two clock edges do not load the output; the third edge is the first one that can.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| src_en | input | 1 | Slow source-rate strobe that qualifies `din` |
| dst_en | input | 1 | Fast destination-rate strobe that marks output slots |
| din | input | DATA_W | Signed input sample |
| dout | output | DATA_W | Registered signed output sample |

## Verification
The two strobes can fall in the same cycle. When they do, the load of a new word must win over the mode's fill action: a zero in zero-fill mode, a hold in hold mode. The bench provokes this by firing `src_en` on destination slots at regular spacing, at wider spacing, and at random spacing. It also drives `src_en` alone on cycles with no destination slot, where the strobe must be ignored. Both modes are instantiated side by side on the same stimulus. A behavioural model predicts each output on every clock, and the bench judges each prediction against the port value.

// File: rtl/ups_pkg.sv
package ups_pkg;

  // Fill behaviour for the slots between two source strobes.
  typedef enum logic {
    UPS_HOLD      = 1'b0,
    UPS_ZERO_FILL = 1'b1
  } ups_mode_e;

  localparam int unsigned UPS_SYNC_STAGES = 2;

endpackage

// File: rtl/ups_rst_sync.sv
module ups_rst_sync #(
  parameter int unsigned STAGES = ups_pkg::UPS_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ups_slot_select.sv
module ups_slot_select
  import ups_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter ups_mode_e   MODE   = UPS_ZERO_FILL
) (
  input  logic              src_en,
  input  logic              dst_en,
  input  logic [DATA_W-1:0] din,
  output logic              load,
  output logic [DATA_W-1:0] nxt
);

  localparam logic [DATA_W-1:0] ZERO_WORD = '0;

  if (MODE == UPS_HOLD) begin : g_hold
    // The register itself repeats the word; only a new sample loads.
    always_comb begin
      load = src_en & dst_en;
      nxt  = din;
    end
  end else begin : g_zero_fill
    // Every destination slot loads; only the first one carries data.
    always_comb begin
      load = dst_en;
      nxt  = src_en ? din : ZERO_WORD;
    end
  end

endmodule

// File: rtl/ups_out_reg.sv
module ups_out_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] nxt,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) begin
      q_d = nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/ce_upsampler.sv
module ce_upsampler
  import ups_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FACTOR = 4,
  parameter ups_mode_e   MODE   = UPS_ZERO_FILL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_en,
  input  logic              dst_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  if (FACTOR < 2) begin : g_bad_factor
    $error("ce_upsampler: FACTOR must be at least 2");
  end

  logic              rst_sync_n;
  logic              slot_load;
  logic [DATA_W-1:0] slot_nxt;

  ups_rst_sync #(
    .STAGES (UPS_SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ups_slot_select #(
    .DATA_W (DATA_W),
    .MODE   (MODE)
  ) u_slot_select (
    .src_en (src_en),
    .dst_en (dst_en),
    .din    (din),
    .load   (slot_load),
    .nxt    (slot_nxt)
  );

  ups_out_reg #(
    .DATA_W (DATA_W)
  ) u_out_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (slot_load),
    .nxt   (slot_nxt),
    .q     (dout)
  );

endmodule

// File: rtl/ce_upsampler_chk.sv
module ce_upsampler_chk
  import ups_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter ups_mode_e   MODE   = UPS_ZERO_FILL
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              src_en,
  input logic              dst_en,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout
);

  // R1: output is cleared whenever the internal reset is active
  always @(negedge clk) begin
    if (!rst_ok) begin
      assert_reset_clear_R1: assert (dout == '0);
    end
  end

  // R2: no destination strobe, no change
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !dst_en |=> $stable(dout));

  // R3: coinciding strobes load the input word
  assert_load_word_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (src_en && dst_en) |=> (dout == $past(din)));

  if (MODE == UPS_HOLD) begin : g_chk_hold
    // R4: fill slots repeat the held word
    assert_fill_repeat_R4: assert property (@(posedge clk) disable iff (!rst_ok)
      (dst_en && !src_en) |=> $stable(dout));
  end else begin : g_chk_zero
    // R5: fill slots carry zero
    assert_fill_zero_R5: assert property (@(posedge clk) disable iff (!rst_ok)
      (dst_en && !src_en) |=> (dout == '0));
  end

endmodule

bind ce_upsampler ce_upsampler_chk #(
  .DATA_W (DATA_W),
  .MODE   (MODE)
) u_ce_upsampler_chk (
  .clk    (clk),
  .rst_ok (rst_sync_n),
  .src_en (src_en),
  .dst_en (dst_en),
  .din    (din),
  .dout   (dout)
);

// File: tb/ce_upsampler_bench.sv
module ce_upsampler_bench;
  import ups_pkg::*;

  localparam int unsigned DW = 8;
  localparam int unsigned L  = 4;

  logic          clk;
  logic          rst_n;
  logic          src_en;
  logic          dst_en;
  logic [DW-1:0] din;
  logic [DW-1:0] dout_z;
  logic [DW-1:0] dout_h;

  int checks;
  int failures;
  bit done;

  // behavioural model state
  logic [DW-1:0] exp_z;
  logic [DW-1:0] exp_h;
  int            sync_cnt;
  string         phase_tag;

  ce_upsampler #(.DATA_W(DW), .FACTOR(L), .MODE(UPS_ZERO_FILL)) u_ce_upsampler (
    .clk (clk), .rst_n (rst_n), .src_en (src_en), .dst_en (dst_en),
    .din (din), .dout (dout_z)
  );

  ce_upsampler #(.DATA_W(DW), .FACTOR(L), .MODE(UPS_HOLD)) u_ce_upsampler_hold (
    .clk (clk), .rst_n (rst_n), .src_en (src_en), .dst_en (dst_en),
    .din (din), .dout (dout_h)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, $signed(act), $signed(exp), $time);
    end
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge.
  task automatic cyc(input logic s, input logic d, input logic [DW-1:0] x);
    string tz;
    string th;
    src_en = s;
    dst_en = d;
    din    = x;
    @(posedge clk);
    if (!rst_n) begin
      exp_z = '0; exp_h = '0; sync_cnt = 0;
      tz = "R1"; th = "R1";
    end else if (sync_cnt < 2) begin
      sync_cnt++;
      tz = "R9"; th = "R9";
    end else if (!d) begin
      tz = "R2"; th = "R2";
    end else if (s) begin
      exp_z = x; exp_h = x;
      tz = "R3"; th = "R3";
    end else begin
      exp_z = '0;
      tz = "R5"; th = "R4";
    end
    if (phase_tag != "") begin
      tz = phase_tag; th = phase_tag;
    end
    @(negedge clk);
    check({tz, " zero-fill"}, dout_z, exp_z);
    check({th, " hold"}, dout_h, exp_h);
  endtask

  // One input period: source strobe in the first of L slots, gap cycles between slots.
  task automatic period(input logic [DW-1:0] x, input int gap);
    for (int k = 0; k < L; k++) begin
      cyc(k == 0, 1'b1, x);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 8'h33);
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    exp_z = '0; exp_h = '0; sync_cnt = 0; phase_tag = "";
    rst_n = 1'b0; src_en = 1'b0; dst_en = 1'b0; din = '0;
    @(negedge clk);
    // R1: reset state, even with strobes active
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 8'h7E);
    // R9: synchronised release; strobes and data held for three edges
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 8'h5A);
    // R6 / R7: regular periods, destination strobe every cycle
    phase_tag = "R6/R7";
    period(8'd5, 0);
    period(8'd7, 0);
    period(8'd24, 0);
    // wider spacing between destination slots
    period(8'd11, 1);
    period(8'd6, 2);
    // R8: signed values
    phase_tag = "R8";
    period(8'hFB, 0);   // -5
    period(8'h80, 0);   // -128
    period(8'h7F, 0);   // 127
    period(8'h00, 0);
    phase_tag = "";
    // R2: source strobe alone and idle cycles are ignored
    period(8'd9, 0);
    cyc(1'b1, 1'b0, 8'h44);
    cyc(1'b0, 1'b0, 8'h55);
    cyc(1'b1, 1'b0, 8'hC3);
    period(8'd13, 0);
    cyc(1'b1, 1'b0, 8'h21);
    cyc(1'b1, 1'b0, 8'h22);
    // random destination spacing with aligned source strobes
    begin
      int slot;
      slot = 0;
      for (int i = 0; i < 300; i++) begin
        logic d;
        logic [DW-1:0] x;
        d = 1'($urandom_range(0, 1));
        x = DW'($urandom);
        cyc(d && (slot == 0), d, x);
        if (d) slot = (slot + 1) % L;
      end
    end
    // R1: asynchronous reset mid-run clears at once
    period(8'd77, 0);
    cyc(1'b1, 1'b1, 8'h66);
    #2 rst_n = 1'b0;
    #1;
    check("R1 zero-fill async", dout_z, '0);
    check("R1 hold async", dout_h, '0);
    exp_z = '0; exp_h = '0; sync_cnt = 0;
    @(negedge clk);
    cyc(1'b1, 1'b1, 8'h12);
    rst_n = 1'b1;
    // R9 again after the second release
    cyc(1'b1, 1'b1, 8'h34);
    cyc(1'b1, 1'b1, 8'h35);
    cyc(1'b0, 1'b1, 8'h36);
    period(8'hF0, 0);
    period(8'd3, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule